// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Edge Select

This block gathers seven interrupt sources for a small 8-bit processor and decides which of them the processor should service next. Two sources are asynchronous external pins. Each pin is synchronized and then passed through an edge detector. Software picks falling, rising or both edges for each pin, or turns the pin off. The other five sources are single-cycle event pulses from neighbouring blocks:

- two timer compare matches
- an ADC conversion-done event
- a watchdog match, counted only while the watchdog runs in interval mode
- an interval-timer overflow

Each source has a request flag and an enable bit. Both live in byte-wide registers on a simple read/write bus. The master enable is held here and driven by enable, disable and return pulses from the processor. It is also cleared automatically when the processor takes an interrupt.

Towards the processor, `irq_req` and `irq_vec` act as a valid, and `irq_ack` acts as the ready. The request stays asserted until it is acknowledged. The vector is re-evaluated every cycle, so a higher-priority arrival before the acknowledge replaces the index on offer. An acknowledge while `irq_req` is low has no effect. `wake` rises for any enabled pending request, whatever the master enable, so the processor can leave its stop state.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all request flags, all enable bits and `mie` are 0, `irq_req` and `wake` are 0, and the edge register (address 4) reads 0x05.
- R2: The edge code for pin 0 is in bits [1:0] of address 4 and the code for pin 1 is in bits [3:2]. The codes are: 01 falling, 10 rising, 11 both, 00 off. A selected transition on a pin sets that pin's flag at the third rising clock edge after the pin changes. This delay comes from two synchronizer stages and one history register.
- R3: A one-cycle pulse on `tmr0_match`, `tmr1_match`, `adc_done` or `itv_overflow` sets that source's flag. A pulse on `wdt_match` sets the watchdog flag only while `wdt_interval_mode` is 1.
- R4: The flag and enable registers share one bit layout. The high flags are at address 0 and the high enables at address 2: bit 7 external 0, bit 6 external 1, bit 5 timer 0, bit 4 timer 1. The low flags are at address 1 and the low enables at address 3: bit 7 ADC, bit 6 watchdog, bit 5 interval timer. Unused bits read 0. A write replaces the stored bits with the written value.
- R5: If a source event and a bus write that clears the same flag fall in the same cycle, the flag ends up set.
- R6: `irq_req` is 1 exactly when `mie` is 1 and at least one source has both its flag and its enable set. A source whose enable is 0 never causes a request.
- R7: `irq_vec` gives the winning source. The order from highest to lowest priority is external 0 (0), external 1 (1), timer 0 (2), timer 1 (3), ADC (4), watchdog (5), interval timer (6).
- R8: When `irq_ack` is high while `irq_req` is high:
  - `mie` clears.
  - If the winner is an external pin, its flag clears.
  - The flag of an internal source is kept.
  - An `irq_ack` while `irq_req` is low changes nothing.
- R9: `reti_pulse` and `ei_pulse` set `mie`. `di_pulse` clears it. When a clear and a set fall in the same cycle, the clear wins.
- R10: `wake` is 1 whenever at least one source has both its flag and its enable set, whatever the value of `mie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_pin | input | 2 | Asynchronous external interrupt pins |
| tmr0_match | input | 1 | Timer 0 compare-match pulse |
| tmr1_match | input | 1 | Timer 1 compare-match pulse |
| adc_done | input | 1 | ADC conversion-complete pulse |
| wdt_match | input | 1 | Watchdog match pulse |
| wdt_interval_mode | input | 1 | 1 when the watchdog is in interval (not reset) mode |
| itv_overflow | input | 1 | Interval-timer overflow pulse |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, used together with bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ei_pulse | input | 1 | Enable-interrupts instruction pulse |
| di_pulse | input | 1 | Disable-interrupts instruction pulse |
| reti_pulse | input | 1 | Return-from-interrupt pulse |
| irq_ack | input | 1 | Processor takes the offered interrupt |
| irq_req | output | 1 | Interrupt offered to the processor |
| irq_vec | output | 3 | Index of the winning source |
| mie | output | 1 | Master interrupt enable (status word bit 2) |
| wake | output | 1 | Release from stop state |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. With that depth, the pin-to-flag delay is a fixed three clock edges. This lets the bench check, cycle by cycle, both that a flag is not yet set one edge early and that it is set on the edge it should be. The seven-source layout is fixed. Under this one build, every priority pair, every edge code, the watchdog mode gate and the set-versus-clear collision can each be driven directly.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC  = 7;
  localparam int N_EXT  = 2;
  localparam int N_HI   = 4;
  localparam int VEC_W  = $clog2(N_SRC);
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_e;

  localparam logic [2:0] A_REQ_HI = 3'd0;
  localparam logic [2:0] A_REQ_LO = 3'd1;
  localparam logic [2:0] A_EN_HI  = 3'd2;
  localparam logic [2:0] A_EN_LO  = 3'd3;
  localparam logic [2:0] A_EDGE   = 3'd4;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       evt
);
  import irq_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;
  logic                   now_lvl;

  assign now_lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      hist_q <= now_lvl;
    end
  end

  always_comb begin
    evt = (sel[0] & hist_q & ~now_lvl) | (sel[1] & ~hist_q & now_lvl);
  end

  p_edge_off_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == EDGE_OFF) |-> !evt);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] wr_en,
  input  logic [N-1:0] wr_val,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_evt[i]) flags[i] <= 1'b1;
      else if (ack_clr[i]) flags[i] <= 1'b0;
      else if (wr_en[i])   flags[i] <= wr_val[i];
    end

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flags[i]);
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_clr[i] && !set_evt[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 7,
  parameter int VW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [VW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = VW'(i);
    end
    any = |req;
  end

  logic [N-1:0] low_mask;
  always_comb begin
    low_mask = (N'(1) << idx) - N'(1);
    if (any) begin
      p_winner_pending_r7: assert (req[idx]);
      p_no_higher_r7: assert ((req & low_mask) == '0);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [irq_pkg::N_EXT-1:0] ext_pin,
  input  logic                      tmr0_match,
  input  logic                      tmr1_match,
  input  logic                      adc_done,
  input  logic                      wdt_match,
  input  logic                      wdt_interval_mode,
  input  logic                      itv_overflow,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [2:0]                bus_addr,
  input  logic [7:0]                bus_wdata,
  output logic [7:0]                bus_rdata,
  input  logic                      ei_pulse,
  input  logic                      di_pulse,
  input  logic                      reti_pulse,
  input  logic                      irq_ack,
  output logic                      irq_req,
  output logic [irq_pkg::VEC_W-1:0] irq_vec,
  output logic                      mie,
  output logic                      wake
);
  import irq_pkg::*;

  localparam logic [2*N_EXT-1:0] EDGE_RST = {N_EXT{EDGE_FALL}};

  logic [2*N_EXT-1:0] edge_q;
  logic [N_EXT-1:0]   ext_evt;
  logic [N_SRC-1:0]   set_evt, wr_en, wr_val, ack_clr, flags, en_q, pending;
  logic               any_pend, ack_take, bus_we;
  logic [VEC_W-1:0]   win_idx;

  assign bus_we = bus_sel & bus_wr;

  for (genvar p = 0; p < N_EXT; p++) begin : g_pin
    irq_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin[p]),
      .sel(edge_q[2*p +: 2]), .evt(ext_evt[p]));
  end

  assign set_evt = {itv_overflow, wdt_match & wdt_interval_mode, adc_done,
                    tmr1_match, tmr0_match, ext_evt};

  for (genvar i = 0; i < N_SRC; i++) begin : g_map
    localparam int       BIT   = (i < N_HI) ? (BYTE_W - 1 - i) : (BYTE_W - 1 - (i - N_HI));
    localparam logic [2:0] FADDR = (i < N_HI) ? A_REQ_HI : A_REQ_LO;
    localparam logic [2:0] EADDR = (i < N_HI) ? A_EN_HI : A_EN_LO;
    assign wr_en[i]   = bus_we && (bus_addr == FADDR);
    assign wr_val[i]  = bus_wdata[BIT];
    assign ack_clr[i] = (i < N_EXT) && ack_take && (win_idx == VEC_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            en_q[i] <= 1'b0;
      else if (bus_we && bus_addr == EADDR) en_q[i] <= bus_wdata[BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             edge_q <= EDGE_RST;
    else if (bus_we && bus_addr == A_EDGE) edge_q <= bus_wdata[2*N_EXT-1:0];
  end

  irq_flag_bank #(.N(N_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .wr_en(wr_en),
    .wr_val(wr_val), .ack_clr(ack_clr), .flags(flags));

  assign pending = flags & en_q;

  irq_prio_enc #(.N(N_SRC), .VW(VEC_W)) u_prio (
    .req(pending), .any(any_pend), .idx(win_idx));

  assign irq_req  = mie & any_pend;
  assign irq_vec  = win_idx;
  assign wake     = any_pend;
  assign ack_take = irq_ack & irq_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       mie <= 1'b0;
    else if (ack_take || di_pulse)    mie <= 1'b0;
    else if (ei_pulse || reti_pulse)  mie <= 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (i < N_HI) begin
        if (bus_addr == A_REQ_HI) bus_rdata[BYTE_W-1-i] = flags[i];
        if (bus_addr == A_EN_HI)  bus_rdata[BYTE_W-1-i] = en_q[i];
      end else begin
        if (bus_addr == A_REQ_LO) bus_rdata[BYTE_W-1-(i-N_HI)] = flags[i];
        if (bus_addr == A_EN_LO)  bus_rdata[BYTE_W-1-(i-N_HI)] = en_q[i];
      end
    end
    if (bus_addr == A_EDGE) bus_rdata[2*N_EXT-1:0] = edge_q;
  end

  p_ack_drops_mie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> !mie);
  p_set_mie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ei_pulse || reti_pulse) && !ack_take && !di_pulse) |=> mie);
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    di_pulse |=> !mie);
  p_req_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en_q[irq_vec] && flags[irq_vec]));
  p_wdt_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_interval_mode && !wr_en[5] && !flags[5]) |=> !flags[5]);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_pin = '0;
  logic       tmr0_match = 0, tmr1_match = 0, adc_done = 0, wdt_match = 0;
  logic       wdt_interval_mode = 0, itv_overflow = 0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ei_pulse = 0, di_pulse = 0, reti_pulse = 0, irq_ack = 0;
  logic       irq_req, mie, wake;
  logic [2:0] irq_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr0_match(tmr0_match),
    .tmr1_match(tmr1_match), .adc_done(adc_done), .wdt_match(wdt_match),
    .wdt_interval_mode(wdt_interval_mode), .itv_overflow(itv_overflow),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ei_pulse(ei_pulse),
    .di_pulse(di_pulse), .reti_pulse(reti_pulse), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec), .mie(mie), .wake(wake));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic chk_rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: tmr0_match = 1; 1: tmr1_match = 1; 2: adc_done = 1;
      3: wdt_match = 1;  4: itv_overflow = 1; 5: ei_pulse = 1;
      6: di_pulse = 1;   7: reti_pulse = 1;  default: irq_ack = 1;
    endcase
    step(1);
    {tmr0_match, tmr1_match, adc_done, wdt_match, itv_overflow} = '0;
    {ei_pulse, di_pulse, reti_pulse, irq_ack} = '0;
  endtask

  task automatic t_reset;
    chk_rd("R1 flags hi", 3'd0, 8'h00);
    chk_rd("R1 flags lo", 3'd1, 8'h00);
    chk_rd("R1 en hi", 3'd2, 8'h00);
    chk_rd("R1 en lo", 3'd3, 8'h00);
    chk_rd("R1 edge", 3'd4, 8'h05);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 wake", wake, 0);
    chk("R1 mie", mie, 0);
  endtask

  task automatic t_edges;
    ext_pin[0] = 1; step(3);
    chk_rd("R2 rise ignored when falling", 3'd0, 8'h00);
    ext_pin[0] = 0; step(2);
    chk_rd("R2 not before third edge", 3'd0, 8'h00);
    step(1);
    chk_rd("R2 falling sets ext0", 3'd0, 8'h80);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'b0000_1110);
    ext_pin[0] = 1; step(3);
    chk_rd("R2 rising sets ext0", 3'd0, 8'h80);
    ext_pin[1] = 1; step(3);
    chk_rd("R2 both: rise ext1", 3'd0, 8'hC0);
    wr(3'd0, 8'h00);
    ext_pin[1] = 0; step(3);
    chk_rd("R2 both: fall ext1", 3'd0, 8'h40);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h00);
    ext_pin[0] = 0; ext_pin[1] = 1; step(3);
    ext_pin[1] = 0; step(3);
    chk_rd("R2 code 00 off", 3'd0, 8'h00);
    wr(3'd4, 8'h05);
    chk_rd("R4 edge readback", 3'd4, 8'h05);
  endtask

  task automatic t_internal;
    pulse(0); chk_rd("R3 timer0", 3'd0, 8'h20);
    pulse(1); chk_rd("R3 timer1", 3'd0, 8'h30);
    pulse(2); chk_rd("R3 adc", 3'd1, 8'h80);
    pulse(3); chk_rd("R3 wdt reset mode ignored", 3'd1, 8'h80);
    wdt_interval_mode = 1;
    pulse(3); chk_rd("R3 wdt interval mode", 3'd1, 8'hC0);
    wdt_interval_mode = 0;
    pulse(4); chk_rd("R3 interval timer", 3'd1, 8'hE0);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    chk_rd("R4 write clears lo", 3'd1, 8'h00);
  endtask

  task automatic t_collision;
    pulse(1);
    tmr0_match = 1;
    wr(3'd0, 8'h00);
    tmr0_match = 0;
    chk_rd("R5 set wins over clear", 3'd0, 8'h20);
    wr(3'd0, 8'hFF); chk_rd("R4 hi unused bits zero", 3'd0, 8'hF0);
    wr(3'd1, 8'hFF); chk_rd("R4 lo unused bits zero", 3'd1, 8'hE0);
    wr(3'd2, 8'hFF); chk_rd("R4 enable hi map", 3'd2, 8'hF0);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
  endtask

  task automatic t_prio;
    wr(3'd2, 8'hF0); wr(3'd3, 8'hE0);
    wr(3'd1, 8'hE0);
    chk("R6 no req without mie", irq_req, 0);
    chk("R10 wake without mie", wake, 1);
    pulse(5);
    chk("R9 ei sets mie", mie, 1);
    chk("R6 req", irq_req, 1);
    chk("R7 adc over wdt/itv", irq_vec, 4);
    wr(3'd0, 8'h10); chk("R7 timer1", irq_vec, 3);
    wr(3'd0, 8'h30); chk("R7 timer0", irq_vec, 2);
    wr(3'd0, 8'h70); chk("R7 ext1", irq_vec, 1);
    wr(3'd0, 8'hF0); chk("R7 ext0", irq_vec, 0);
    wr(3'd0, 8'h00); wr(3'd1, 8'h60); chk("R7 wdt", irq_vec, 5);
    wr(3'd1, 8'h20); chk("R7 interval timer", irq_vec, 6);
    wr(3'd3, 8'hC0);
    chk("R6 disabled source no req", irq_req, 0);
    chk("R10 disabled source no wake", wake, 0);
    wr(3'd1, 8'h00); wr(3'd3, 8'hE0);
  endtask

  task automatic t_ack;
    wr(3'd0, 8'h60);
    chk("R7 ext1 offered", irq_vec, 1);
    pulse(8);
    chk("R8 ack clears mie", mie, 0);
    chk("R8 req drops", irq_req, 0);
    chk("R10 wake stays", wake, 1);
    chk_rd("R8 ext flag cleared", 3'd0, 8'h20);
    pulse(7);
    chk("R9 reti sets mie", mie, 1);
    chk("R7 timer0 next", irq_vec, 2);
    pulse(8);
    chk("R8 ack clears mie again", mie, 0);
    chk_rd("R8 internal flag kept", 3'd0, 8'h20);
    wr(3'd0, 8'h00);
    ei_pulse = 1; pulse(6);
    chk("R9 clear wins", mie, 0);
    pulse(5);
    pulse(8);
    chk("R8 ack without req ignored", mie, 1);
    pulse(6);
    chk("R9 di clears", mie, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_edges();
    t_internal();
    t_collision();
    t_prio();
    t_ack();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule